// File: doc/BRIEF.md
# Register Operate-Group Unit

This unit carries out register-to-register instructions on a small register file holding an accumulator (A), a second working register (B), an index register (X) and an optional extension register (E). One 16-bit instruction names a source register, a destination register, one of eight functions and one of four skip tests. In one clock edge the unit writes the function result into the destination and tests that new value. The outcome of the test is a skip flag that tells the instruction sequencer to advance its location counter by two instead of one.

The sequencer fills registers through a load port and watches any register through a read port. When the extension register is left out at build time (`HAS_EXT = 0`), the register file has three entries. An instruction that names E is then refused: no register changes and an illegal flag is raised.

Top module: `opg_alu`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `skip_o`, `done_o` and `illegal_o` are low and every register reads zero.
- R2: An instruction is accepted only when `insn_valid` is high, `insn[15:12]` is 4'b0000, `insn[11:10]` is 2'b10 and the reserved bit `insn[9]` is 0. Any other word changes no register and leaves all three flags low.
- R3: Fields are decoded as follows: function `insn[8:6]`, test `insn[5:4]`, source `insn[3:2]` and destination `insn[1:0]`. Register codes are A=0, B=1, X=2 and E=3.
- R4: Function codes 0 to 3 write, in order: S, S+1, S+D, and S XOR D.
- R5: Function codes 4 to 7 write, in order: the bitwise inverse of S, the two's-complement negation of S, S-1, and S-D.
- R6: The test is applied to the newly written destination value. Code 0 never skips. Code 1 skips when the value is nonzero with MSB 0. Code 2 skips when the MSB is 1. Code 3 skips when the value is zero.
- R7: The write, `done_o` and `skip_o` all take effect on the edge that accepts the instruction. `done_o` lasts one cycle per instruction. `rd_data` follows `rd_sel` without a clock.
- R8: With `HAS_EXT = 0`, an accepted instruction whose source or destination is E sets `illegal_o` for one cycle, keeps `done_o` and `skip_o` low and changes no register. Reading E returns zero.
- R9: `ld_en` writes `ld_data` into register `ld_sel`. If an instruction writes the same register in the same cycle, the instruction result wins. Writes to different registers in the same cycle both happen.
- R10: A source equal to the destination reads the old value for both operands, so S+D doubles the register and S XOR D clears it.
- R11: Arithmetic wraps modulo 2^16: 7FFF+1 = 8000, negating 8000 gives 8000, and 0-1 = FFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word present this cycle |
| insn | input | 16 | Instruction word |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 2 | Register code to load |
| ld_data | input | DATA_W | Load value |
| rd_sel | input | 2 | Register code to observe |
| rd_data | output | DATA_W | Contents of the selected register |
| skip_o | output | 1 | Skip the next word (advance by two) |
| done_o | output | 1 | An instruction was executed |
| illegal_o | output | 1 | Instruction named an absent register |

## Verification
The checker checks several properties on every cycle. A skip only comes with a completed instruction, and an illegal refusal never completes. Idle cycles and foreign opcodes raise no flag, and test code 0 never skips. When the observed register is the destination, the zero and negative tests agree with the value written. Only the bench's scenarios can show the arithmetic of each of the eight functions, wraparound, aliasing of source and destination, the priority of the load port against an instruction, and the fact that a refused instruction leaves the register contents unchanged.

// File: rtl/opg_pkg.sv
package opg_pkg;

  localparam int INSN_W  = 16;
  localparam int REG_AW  = 2;

  localparam logic [3:0] OPG_MAJOR = 4'b0000;
  localparam logic [1:0] OPG_GROUP = 2'b10;

  typedef enum logic [2:0] {
    FN_MOVE = 3'd0,
    FN_INC  = 3'd1,
    FN_ADD  = 3'd2,
    FN_XOR  = 3'd3,
    FN_NOT  = 3'd4,
    FN_NEG  = 3'd5,
    FN_DEC  = 3'd6,
    FN_SUB  = 3'd7
  } opg_fn_e;

  typedef enum logic [1:0] {
    TS_NONE = 2'd0,
    TS_POS  = 2'd1,
    TS_NEG  = 2'd2,
    TS_ZERO = 2'd3
  } opg_test_e;

  typedef struct packed {
    opg_fn_e             fn;
    opg_test_e           test;
    logic [REG_AW-1:0]   src;
    logic [REG_AW-1:0]   dst;
  } opg_dec_t;

endpackage

// File: rtl/opg_decode.sv
module opg_decode
  import opg_pkg::*;
#(
  parameter bit HAS_EXT = 1'b1
) (
  input  logic              valid,
  input  logic [INSN_W-1:0] insn,
  output opg_dec_t          dec,
  output logic              go,
  output logic              refuse
);

  localparam logic [REG_AW-1:0] EXT_CODE = REG_AW'(3);

  logic hit;
  logic uses_ext;

  always_comb begin
    dec.fn   = opg_fn_e'(insn[8:6]);
    dec.test = opg_test_e'(insn[5:4]);
    dec.src  = insn[3:2];
    dec.dst  = insn[1:0];
  end

  assign hit = valid
            && (insn[15:12] == OPG_MAJOR)
            && (insn[11:10] == OPG_GROUP)
            && !insn[9];

  generate
    if (HAS_EXT) begin : g_full
      assign uses_ext = 1'b0;
    end else begin : g_reduced
      assign uses_ext = (dec.src == EXT_CODE) || (dec.dst == EXT_CODE);
    end
  endgenerate

  assign go     = hit && !uses_ext;
  assign refuse = hit && uses_ext;

endmodule

// File: rtl/opg_regfile.sv
module opg_regfile
  import opg_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ld_en,
  input  logic [REG_AW-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [REG_AW-1:0] s_addr,
  input  logic [REG_AW-1:0] d_addr,
  input  logic [REG_AW-1:0] r_addr,
  output logic [DATA_W-1:0] s_data,
  output logic [DATA_W-1:0] d_data,
  output logic [DATA_W-1:0] r_data
);

  logic [DATA_W-1:0] q [NUM_REGS];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_ent
      localparam logic [REG_AW-1:0] IDX = REG_AW'(gi);
      always_ff @(posedge clk) begin
        if (rst) begin
          q[gi] <= '0;
        end else if (we && (waddr == IDX)) begin
          q[gi] <= wdata;
        end else if (ld_en && (ld_addr == IDX)) begin
          q[gi] <= ld_data;
        end
      end
    end
  endgenerate

  always_comb begin
    s_data = '0;
    d_data = '0;
    r_data = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (s_addr == REG_AW'(k)) s_data = q[k];
      if (d_addr == REG_AW'(k)) d_data = q[k];
      if (r_addr == REG_AW'(k)) r_data = q[k];
    end
  end

endmodule

// File: rtl/opg_func.sv
module opg_func
  import opg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  opg_fn_e           fn,
  input  logic [DATA_W-1:0] s,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] r
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    unique case (fn)
      FN_MOVE: r = s;
      FN_INC:  r = s + ONE;
      FN_ADD:  r = s + d;
      FN_XOR:  r = s ^ d;
      FN_NOT:  r = ~s;
      FN_NEG:  r = ~s + ONE;
      FN_DEC:  r = s - ONE;
      FN_SUB:  r = s - d;
      default: r = s;
    endcase
  end

endmodule

// File: rtl/opg_skip.sv
module opg_skip
  import opg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  opg_test_e         test,
  input  logic [DATA_W-1:0] val,
  output logic              skip
);

  logic is_zero;
  logic is_neg;

  assign is_zero = (val == '0);
  assign is_neg  = val[DATA_W-1];

  always_comb begin
    unique case (test)
      TS_NONE: skip = 1'b0;
      TS_POS:  skip = !is_neg && !is_zero;
      TS_NEG:  skip = is_neg;
      TS_ZERO: skip = is_zero;
      default: skip = 1'b0;
    endcase
  end

endmodule

// File: rtl/opg_alu.sv
module opg_alu
  import opg_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter bit HAS_EXT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_valid,
  input  logic [15:0]       insn,
  input  logic              ld_en,
  input  logic [1:0]        ld_sel,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              skip_o,
  output logic              done_o,
  output logic              illegal_o
);

  localparam int NUM_REGS = HAS_EXT ? 4 : 3;

  opg_dec_t          dec;
  logic              go;
  logic              refuse;
  logic [DATA_W-1:0] s_val;
  logic [DATA_W-1:0] d_val;
  logic [DATA_W-1:0] res;
  logic              skip_nx;

  opg_decode #(.HAS_EXT(HAS_EXT)) u_dec (
    .valid  (insn_valid),
    .insn   (insn),
    .dec    (dec),
    .go     (go),
    .refuse (refuse)
  );

  opg_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (go),
    .waddr   (dec.dst),
    .wdata   (res),
    .ld_en   (ld_en),
    .ld_addr (ld_sel),
    .ld_data (ld_data),
    .s_addr  (dec.src),
    .d_addr  (dec.dst),
    .r_addr  (rd_sel),
    .s_data  (s_val),
    .d_data  (d_val),
    .r_data  (rd_data)
  );

  opg_func #(.DATA_W(DATA_W)) u_fn (
    .fn (dec.fn),
    .s  (s_val),
    .d  (d_val),
    .r  (res)
  );

  opg_skip #(.DATA_W(DATA_W)) u_skip (
    .test (dec.test),
    .val  (res),
    .skip (skip_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      skip_o    <= 1'b0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      skip_o    <= go && skip_nx;
      done_o    <= go;
      illegal_o <= refuse;
    end
  end

endmodule

// File: rtl/opg_alu_chk.sv
module opg_alu_chk #(
  parameter int DATA_W  = 16,
  parameter bit HAS_EXT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              insn_valid,
  input logic [5:0]        hdr,
  input logic              rsvd,
  input logic [1:0]        test,
  input logic [1:0]        src,
  input logic [1:0]        dst,
  input logic [1:0]        rd_sel,
  input logic [DATA_W-1:0] rd_data,
  input logic              skip_o,
  input logic              done_o,
  input logic              illegal_o
);

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!skip_o && !done_o && !illegal_o));

  // R2
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !insn_valid |=> (!skip_o && !done_o && !illegal_o));

  a_r2_foreign_quiet: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && (hdr != 6'b000010 || rsvd)) |=> (!done_o && !illegal_o));

  // R6
  a_r6_no_test_no_skip: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && test == 2'b00) |=> !skip_o);

  a_r6_zero_test: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(test) == 2'b11 && rd_sel == $past(dst))
      |-> (skip_o == (rd_data == '0)));

  a_r6_neg_test: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(test) == 2'b10 && rd_sel == $past(dst))
      |-> (skip_o == rd_data[DATA_W-1]));

  // R7
  a_r7_skip_needs_done: assert property (@(posedge clk) disable iff (rst)
    skip_o |-> done_o);

  // R8
  a_r8_refusal_exclusive: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (!done_o && !skip_o));

  a_r8_ext_names_refused: assert property (@(posedge clk) disable iff (rst)
    (!HAS_EXT && insn_valid && hdr == 6'b000010 && !rsvd && (src == 2'b11 || dst == 2'b11))
      |=> (illegal_o && !done_o));

endmodule

bind opg_alu opg_alu_chk #(.DATA_W(DATA_W), .HAS_EXT(HAS_EXT)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .insn_valid (insn_valid),
  .hdr        (insn[15:10]),
  .rsvd       (insn[9]),
  .test       (insn[5:4]),
  .src        (insn[3:2]),
  .dst        (insn[1:0]),
  .rd_sel     (rd_sel),
  .rd_data    (rd_data),
  .skip_o     (skip_o),
  .done_o     (done_o),
  .illegal_o  (illegal_o)
);

// File: tb/opg_alu_tb.sv
`timescale 1ns/1ps
module opg_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_valid = 1'b0;
  logic [15:0] insn = '0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_sel = '0;
  logic [15:0] ld_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data, rd_data_n;
  logic        skip, done, illegal;
  logic        skip_n, done_n, illegal_n;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [15:0] model [4];

  always #10 clk = ~clk;

  opg_alu #(.DATA_W(16), .HAS_EXT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn(insn),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .skip_o(skip), .done_o(done), .illegal_o(illegal));

  opg_alu #(.DATA_W(16), .HAS_EXT(1'b0)) dut_noe_i (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn(insn),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .rd_sel(rd_sel), .rd_data(rd_data_n),
    .skip_o(skip_n), .done_o(done_n), .illegal_o(illegal_n));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [2:0] fn, input logic [1:0] ts,
                                     input logic [1:0] s, input logic [1:0] d);
    return {4'b0000, 2'b10, 1'b0, fn, ts, s, d};
  endfunction

  function automatic logic [15:0] ref_fn(input logic [2:0] fn, input logic [15:0] s,
                                         input logic [15:0] d);
    case (fn)
      3'd0: return s;
      3'd1: return s + 16'd1;
      3'd2: return s + d;
      3'd3: return s ^ d;
      3'd4: return ~s;
      3'd5: return 16'd0 - s;
      3'd6: return s - 16'd1;
      default: return s - d;
    endcase
  endfunction

  function automatic logic ref_skip(input logic [1:0] ts, input logic [15:0] v);
    case (ts)
      2'd0: return 1'b0;
      2'd1: return (v != 0) && !v[15];
      2'd2: return v[15];
      default: return v == 0;
    endcase
  endfunction

  task automatic read_reg(input logic [1:0] sel, output logic [15:0] v, output logic [15:0] vn);
    rd_sel = sel;
    #1;
    v = rd_data;
    vn = rd_data_n;
  endtask

  task automatic do_load(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_data = val;
    @(posedge clk); #1;
    ld_en = 1'b0;
    model[sel] = val;
  endtask

  task automatic do_op(input string tag, input logic [2:0] fn, input logic [1:0] ts,
                       input logic [1:0] s, input logic [1:0] d);
    logic [15:0] exp;
    logic        exps;
    exp  = ref_fn(fn, model[s], model[d]);
    exps = ref_skip(ts, exp);
    @(negedge clk);
    insn = mk(fn, ts, s, d); insn_valid = 1'b1; rd_sel = d;
    @(posedge clk); #1;
    insn_valid = 1'b0;
    chk({tag, " result"}, rd_data, exp);
    chk({tag, " skip"}, {15'd0, skip}, {15'd0, exps});
    chk({tag, " done"}, {15'd0, done}, 16'd1);
    model[d] = exp;
  endtask

  task automatic t_reset;
    logic [15:0] v, vn;
    chk("R1 skip", {15'd0, skip}, 16'd0);
    chk("R1 done", {15'd0, done}, 16'd0);
    chk("R1 illegal", {15'd0, illegal}, 16'd0);
    for (int r = 0; r < 4; r++) begin
      read_reg(2'(r), v, vn);
      chk("R1 reg zero", v, 16'd0);
      chk("R1 reg zero reduced", vn, 16'd0);
      model[r] = 16'd0;
    end
  endtask

  task automatic t_load;
    logic [15:0] v, vn;
    do_load(2'd0, 16'h1234);
    do_load(2'd1, 16'h00F0);
    do_load(2'd2, 16'h8001);
    do_load(2'd3, 16'h0005);
    for (int r = 0; r < 4; r++) begin
      read_reg(2'(r), v, vn);
      chk("R9 load readback", v, model[r]);
    end
  endtask

  task automatic t_funcs_low;
    do_op("R4 R3 move B->A", 3'd0, 2'd0, 2'd1, 2'd0);
    do_op("R4 inc X->B",     3'd1, 2'd0, 2'd2, 2'd1);
    do_op("R4 add A+B->X",   3'd2, 2'd0, 2'd0, 2'd2);
    do_op("R4 xor E^A->A",   3'd3, 2'd0, 2'd3, 2'd0);
  endtask

  task automatic t_funcs_high;
    do_op("R5 not A->E",     3'd4, 2'd0, 2'd0, 2'd3);
    do_op("R5 neg B->X",     3'd5, 2'd0, 2'd1, 2'd2);
    do_op("R5 dec E->B",     3'd6, 2'd0, 2'd3, 2'd1);
    do_op("R5 sub A-X->A",   3'd7, 2'd0, 2'd0, 2'd2);
  endtask

  task automatic t_skip;
    do_load(2'd0, 16'h0003);
    do_load(2'd1, 16'h0003);
    do_op("R6 pos on positive",  3'd0, 2'd1, 2'd0, 2'd2);
    do_op("R6 zero on nonzero",  3'd0, 2'd3, 2'd0, 2'd2);
    do_op("R6 zero on zero",     3'd7, 2'd3, 2'd0, 2'd1);
    do_op("R6 pos on zero",      3'd7, 2'd1, 2'd0, 2'd0);
    do_op("R6 neg on negative",  3'd6, 2'd2, 2'd0, 2'd3);
    do_op("R6 pos on negative",  3'd0, 2'd1, 2'd3, 2'd2);
    do_op("R6 none on zero",     3'd0, 2'd0, 2'd1, 2'd2);
  endtask

  task automatic t_decode;
    logic [15:0] bad [3];
    logic [15:0] v, vn;
    bad[0] = mk(3'd1, 2'd3, 2'd0, 2'd0) | 16'h4000;
    bad[1] = (mk(3'd1, 2'd3, 2'd0, 2'd0) & 16'hF3FF) | 16'h0400;
    bad[2] = mk(3'd1, 2'd3, 2'd0, 2'd0) | 16'h0200;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      insn = (i < 3) ? bad[i] : mk(3'd1, 2'd3, 2'd0, 2'd0);
      insn_valid = (i < 3);
      rd_sel = 2'd0;
      @(posedge clk); #1;
      insn_valid = 1'b0;
      chk("R2 done low", {15'd0, done}, 16'd0);
      chk("R2 skip low", {15'd0, skip}, 16'd0);
      read_reg(2'd0, v, vn);
      chk("R2 reg unchanged", v, model[0]);
    end
  endtask

  task automatic t_timing;
    do_op("R7 inc A", 3'd1, 2'd1, 2'd0, 2'd0);
    @(posedge clk); #1;
    chk("R7 done one cycle", {15'd0, done}, 16'd0);
    chk("R7 skip one cycle", {15'd0, skip}, 16'd0);
  endtask

  task automatic t_priority;
    logic [15:0] v, vn;
    do_load(2'd1, 16'h0BEE);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = 2'd0; ld_data = 16'hAAAA;
    insn = mk(3'd0, 2'd0, 2'd1, 2'd0); insn_valid = 1'b1;
    @(posedge clk); #1;
    ld_en = 1'b0; insn_valid = 1'b0;
    model[0] = model[1];
    read_reg(2'd0, v, vn);
    chk("R9 insn beats load", v, 16'h0BEE);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = 2'd2; ld_data = 16'h5555;
    insn = mk(3'd1, 2'd0, 2'd1, 2'd0); insn_valid = 1'b1;
    @(posedge clk); #1;
    ld_en = 1'b0; insn_valid = 1'b0;
    model[0] = 16'h0BEF; model[2] = 16'h5555;
    read_reg(2'd0, v, vn);
    chk("R9 both writes A", v, 16'h0BEF);
    read_reg(2'd2, v, vn);
    chk("R9 both writes X", v, 16'h5555);
  endtask

  task automatic t_alias;
    do_load(2'd2, 16'h1111);
    do_op("R10 add X+X", 3'd2, 2'd0, 2'd2, 2'd2);
    do_op("R10 xor X^X", 3'd3, 2'd3, 2'd2, 2'd2);
    do_op("R10 sub X-X", 3'd7, 2'd3, 2'd2, 2'd2);
  endtask

  task automatic t_wrap;
    do_load(2'd0, 16'h7FFF);
    do_op("R11 inc 7FFF", 3'd1, 2'd2, 2'd0, 2'd1);
    do_op("R11 neg 8000", 3'd5, 2'd2, 2'd1, 2'd2);
    do_load(2'd3, 16'h0000);
    do_op("R11 dec 0", 3'd6, 2'd2, 2'd3, 2'd0);
  endtask

  task automatic t_noext;
    logic [15:0] v, vn, before_n;
    do_load(2'd1, 16'h0042);
    do_load(2'd3, 16'h0009);
    read_reg(2'd3, v, vn);
    chk("R8 E reads zero", vn, 16'd0);
    read_reg(2'd1, v, before_n);
    @(negedge clk);
    insn = mk(3'd0, 2'd1, 2'd3, 2'd1); insn_valid = 1'b1; rd_sel = 2'd1;
    @(posedge clk); #1;
    insn_valid = 1'b0;
    chk("R8 illegal src E", {15'd0, illegal_n}, 16'd1);
    chk("R8 done low", {15'd0, done_n}, 16'd0);
    chk("R8 skip low", {15'd0, skip_n}, 16'd0);
    chk("R8 B unchanged", rd_data_n, before_n);
    chk("R8 full unit executes", rd_data, 16'h0009);
    model[1] = 16'h0009;
    @(negedge clk);
    insn = mk(3'd1, 2'd0, 2'd0, 2'd3); insn_valid = 1'b1;
    @(posedge clk); #1;
    insn_valid = 1'b0;
    chk("R8 illegal dst E", {15'd0, illegal_n}, 16'd1);
    model[3] = model[0] + 16'd1;
    @(posedge clk); #1;
    chk("R8 illegal one cycle", {15'd0, illegal_n}, 16'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    @(negedge clk);
    rst = 1'b0;
    t_load;
    t_funcs_low;
    t_funcs_high;
    t_skip;
    t_decode;
    t_timing;
    t_priority;
    t_alias;
    t_wrap;
    t_noext;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R7 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule